// File: doc/BRIEF.md
# Trap Return Privilege Unit

This block carries out the two trap-return operations of a hart: the return from a machine-level handler and the return from a supervisor-level handler. A one-cycle request names which of the two is wanted. The block receives the hart's current privilege and virtualization state, the interrupt-stacking fields of the machine and hypervisor status registers, the two saved exception PCs, and flags that say which optional features are present. It then decides whether the return is legal.

A legal return produces the following on the next clock edge:
- the restored privilege and virtualization state,
- the unstacked status fields,
- the return PC,
- a commit pulse.

An illegal return produces an exception pulse with a cause code and leaves every held output unchanged. If the return brings virtualization back on, the block raises a one-cycle request to swap the hypervisor shadow registers. The swap is carried out elsewhere, and so is the pipeline flush.

The status fields are exposed as separate bits so that the surrounding CSR file can write them back. The held outputs always show the last committed state.

Top module: `trp_top`

## Requirements
- R1: A supervisor return while the current privilege is user (encoding 0) raises an illegal-instruction exception (cause 2). A machine return while the current privilege is not machine (encoding 3) also raises cause 2.
- R2: If the compressed-instruction flag is clear and either of the two low bits of the selected return PC is set, the block raises an instruction-address-misaligned exception (cause 0). The selected PC is the machine saved PC for a machine return and the supervisor saved PC for a supervisor return. With the flag set, those bits are not checked.
- R3: A supervisor return at supervisor privilege (encoding 1) while the trap-supervisor-return bit is set raises cause 2. At machine privilege that bit has no effect.
- R4: A supervisor return raises a virtual-instruction exception (cause 22) when all three hold: the hypervisor flag is set, virtualization is on, and the virtual trap-supervisor-return bit is set. With the hypervisor flag clear, that bit has no effect.
- R5: A machine return raises cause 2 when all three hold: protection regions are implemented, the rule count is zero, and the saved machine previous privilege is not machine. A nonzero rule count, or a saved privilege of machine, allows the return.
- R6: When several checks fail, only the highest-priority cause is reported. The order from highest to lowest is: privilege, PC alignment, trap-supervisor-return or protection-rule check, virtual trap-supervisor-return.
- R7: A committed supervisor return applies these updates:
  - supervisor interrupt enable takes the old supervisor previous enable;
  - supervisor previous enable becomes 1;
  - supervisor previous privilege becomes 0;
  - privilege takes the old supervisor previous privilege;
  - the return PC is the supervisor saved PC;
  - all machine fields pass through unchanged.
- R8: A committed supervisor return with the hypervisor flag set and virtualization off does three things: virtualization takes the old supervisor previous-virtualization bit, that bit is cleared, and a swap request is pulsed if it was 1. Otherwise virtualization and that bit are unchanged.
- R9: A committed machine return applies these updates:
  - machine interrupt enable takes the old machine previous enable;
  - machine previous enable becomes 1;
  - machine previous privilege becomes 0;
  - machine previous-virtualization becomes 0;
  - privilege takes the old machine previous privilege;
  - the return PC is the machine saved PC.
  With the hypervisor flag set, virtualization also takes the old machine previous-virtualization bit, and a swap request is pulsed if that bit was 1.
- R10: On an exception, none of the held outputs (privilege, virtualization, status fields, return PC) change.
- R11: Exactly one of the commit pulse and the exception pulse goes high, for one cycle, on the clock edge after the edge that sampled a valid request. Neither pulse goes high at any other time.
- R12: After reset the privilege output is machine (3), all other held outputs are 0, and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle trap-return request |
| reqIsMret | input | 1 | 1 = machine return, 0 = supervisor return |
| curPriv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| curVirt | input | 1 | Current virtualization bit |
| mieIn | input | 1 | Machine interrupt enable |
| sieIn | input | 1 | Supervisor interrupt enable |
| mpieIn | input | 1 | Machine previous interrupt enable |
| spieIn | input | 1 | Supervisor previous interrupt enable |
| mppIn | input | 2 | Machine previous privilege |
| sppIn | input | 1 | Supervisor previous privilege |
| mpvIn | input | 1 | Machine previous virtualization |
| tsrIn | input | 1 | Trap supervisor return |
| spvIn | input | 1 | Supervisor previous virtualization (hypervisor status) |
| vtsrIn | input | 1 | Virtual trap supervisor return (hypervisor status) |
| mepc | input | XLEN | Machine saved exception PC |
| sepc | input | XLEN | Supervisor saved exception PC |
| hasC | input | 1 | Compressed-instruction support present |
| hasH | input | 1 | Hypervisor support present |
| pmpPresent | input | 1 | Protection regions implemented |
| pmpRuleCount | input | CNT_W | Number of configured protection rules |
| doneOk | output | 1 | Commit pulse |
| excValid | output | 1 | Exception pulse |
| excCause | output | 5 | Cause of the last exception |
| swapReq | output | 1 | Shadow-register swap request pulse |
| retPc | output | XLEN | Return PC of the last commit |
| privOut | output | 2 | Restored privilege |
| virtOut | output | 1 | Restored virtualization bit |
| mieOut | output | 1 | Updated machine interrupt enable |
| sieOut | output | 1 | Updated supervisor interrupt enable |
| mpieOut | output | 1 | Updated machine previous enable |
| spieOut | output | 1 | Updated supervisor previous enable |
| mppOut | output | 2 | Updated machine previous privilege |
| sppOut | output | 1 | Updated supervisor previous privilege |
| mpvOut | output | 1 | Updated machine previous virtualization |
| spvOut | output | 1 | Updated supervisor previous virtualization |

## Verification
The assertions check the following on every cycle:
- the commit and exception pulses never overlap, and neither appears without a request in the previous cycle;
- the held outputs stay still on an exception;
- every swap request comes with a commit that turned virtualization on;
- privilege violations and misaligned return PCs always map to their causes;
- the stacking rules for both return types hold whenever the request is issued from machine level with no other check in play.

The bench scenarios cover the rest: the trap-supervisor-return and virtual-trap gating, the protection-rule refusal and its exemptions, the cause chosen when several checks fail at once, and the hypervisor virtualization restore. They also show that an exception leaves the previously committed state intact.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

  // strobes from control to datapath
  typedef struct packed {
    logic                commit;
    logic                raise;
    logic [CAUSE_W-1:0]  cause;
    logic                isMret;
    logic                virtFromSaved;
  } trpStrobe_t;

  typedef struct packed {
    logic       mie;
    logic       sie;
    logic       mpie;
    logic       spie;
    logic [1:0] mpp;
    logic       spp;
    logic       mpv;
    logic       spv;
  } trpStatus_t;
endpackage

// File: rtl/trp_ctrl.sv
module trp_ctrl
  import trp_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int ALIGN_LSB = 2
) (
  input  logic                 reqValid,
  input  logic                 reqIsMret,
  input  logic [1:0]           curPriv,
  input  logic                 curVirt,
  input  logic                 tsrIn,
  input  logic                 vtsrIn,
  input  logic [1:0]           mppIn,
  input  logic [ALIGN_LSB-1:0] mepcLow,
  input  logic [ALIGN_LSB-1:0] sepcLow,
  input  logic                 hasC,
  input  logic                 hasH,
  input  logic                 pmpPresent,
  input  logic [CNT_W-1:0]     pmpRuleCount,
  output trpStrobe_t           strobe
);
  logic privFail;
  logic alignFail;
  logic tsrFail;
  logic pmpFail;
  logic vtsrFail;
  logic [ALIGN_LSB-1:0] pcLow;
  logic anyFail;
  logic [CAUSE_W-1:0] causeSel;

  assign pcLow     = reqIsMret ? mepcLow : sepcLow;
  assign privFail  = reqIsMret ? (curPriv != PRIV_M) : (curPriv < PRIV_S);
  assign alignFail = !hasC && (pcLow != '0);
  assign tsrFail   = !reqIsMret && tsrIn && (curPriv != PRIV_M);
  assign pmpFail   = reqIsMret && pmpPresent && (pmpRuleCount == '0) && (mppIn != PRIV_M);
  assign vtsrFail  = !reqIsMret && hasH && curVirt && vtsrIn;
  assign anyFail   = privFail | alignFail | tsrFail | pmpFail | vtsrFail;

  always_comb begin
    if (privFail)                 causeSel = CAUSE_ILLEGAL;
    else if (alignFail)           causeSel = CAUSE_MISALIGN;
    else if (tsrFail || pmpFail)  causeSel = CAUSE_ILLEGAL;
    else if (vtsrFail)            causeSel = CAUSE_VIRT;
    else                          causeSel = CAUSE_MISALIGN;
  end

  always_comb begin
    strobe.commit        = reqValid && !anyFail;
    strobe.raise         = reqValid && anyFail;
    strobe.cause         = causeSel;
    strobe.isMret        = reqIsMret;
    strobe.virtFromSaved = reqIsMret ? hasH : (hasH && !curVirt);
  end
endmodule

// File: rtl/trp_dpath.sv
module trp_dpath
  import trp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  trpStrobe_t         strobe,
  input  logic               curVirt,
  input  trpStatus_t         statIn,
  input  logic [XLEN-1:0]    mepc,
  input  logic [XLEN-1:0]    sepc,
  output logic               doneOk,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic               swapReq,
  output logic [XLEN-1:0]    retPc,
  output logic [1:0]         privOut,
  output logic               virtOut,
  output trpStatus_t         statOut
);
  logic       savedVirt;
  logic [1:0] savedPriv;
  logic       nextVirt;
  trpStatus_t nextStat;

  assign savedVirt = strobe.isMret ? statIn.mpv : statIn.spv;
  assign savedPriv = strobe.isMret ? statIn.mpp : {1'b0, statIn.spp};
  assign nextVirt  = strobe.virtFromSaved ? savedVirt : curVirt;

  always_comb begin
    nextStat = statIn;
    if (strobe.isMret) begin
      nextStat.mie  = statIn.mpie;
      nextStat.mpie = 1'b1;
      nextStat.mpp  = PRIV_U;
      nextStat.mpv  = 1'b0;
    end else begin
      nextStat.sie  = statIn.spie;
      nextStat.spie = 1'b1;
      nextStat.spp  = 1'b0;
      if (strobe.virtFromSaved) nextStat.spv = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneOk   <= 1'b0;
      excValid <= 1'b0;
      excCause <= '0;
      swapReq  <= 1'b0;
      retPc    <= '0;
      privOut  <= PRIV_M;
      virtOut  <= 1'b0;
      statOut  <= '0;
    end else begin
      doneOk   <= strobe.commit;
      excValid <= strobe.raise;
      swapReq  <= strobe.commit && strobe.virtFromSaved && savedVirt;
      if (strobe.raise) excCause <= strobe.cause;
      if (strobe.commit) begin
        retPc   <= strobe.isMret ? mepc : sepc;
        privOut <= savedPriv;
        virtOut <= nextVirt;
        statOut <= nextStat;
      end
    end
  end
endmodule

// File: rtl/trp_top.sv
module trp_top
  import trp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqIsMret,
  input  logic [1:0]         curPriv,
  input  logic               curVirt,
  input  logic               mieIn,
  input  logic               sieIn,
  input  logic               mpieIn,
  input  logic               spieIn,
  input  logic [1:0]         mppIn,
  input  logic               sppIn,
  input  logic               mpvIn,
  input  logic               tsrIn,
  input  logic               spvIn,
  input  logic               vtsrIn,
  input  logic [XLEN-1:0]    mepc,
  input  logic [XLEN-1:0]    sepc,
  input  logic               hasC,
  input  logic               hasH,
  input  logic               pmpPresent,
  input  logic [CNT_W-1:0]   pmpRuleCount,
  output logic               doneOk,
  output logic               excValid,
  output logic [4:0]         excCause,
  output logic               swapReq,
  output logic [XLEN-1:0]    retPc,
  output logic [1:0]         privOut,
  output logic               virtOut,
  output logic               mieOut,
  output logic               sieOut,
  output logic               mpieOut,
  output logic               spieOut,
  output logic [1:0]         mppOut,
  output logic               sppOut,
  output logic               mpvOut,
  output logic               spvOut
);
  localparam int ALIGN_LSB = 2;

  trpStrobe_t strobe;
  trpStatus_t statIn;
  trpStatus_t statOut;

  always_comb begin
    statIn.mie  = mieIn;
    statIn.sie  = sieIn;
    statIn.mpie = mpieIn;
    statIn.spie = spieIn;
    statIn.mpp  = mppIn;
    statIn.spp  = sppIn;
    statIn.mpv  = mpvIn;
    statIn.spv  = spvIn;
  end

  trp_ctrl #(.CNT_W(CNT_W), .ALIGN_LSB(ALIGN_LSB)) u_ctrl (
    .reqValid     (reqValid),
    .reqIsMret    (reqIsMret),
    .curPriv      (curPriv),
    .curVirt      (curVirt),
    .tsrIn        (tsrIn),
    .vtsrIn       (vtsrIn),
    .mppIn        (mppIn),
    .mepcLow      (mepc[ALIGN_LSB-1:0]),
    .sepcLow      (sepc[ALIGN_LSB-1:0]),
    .hasC         (hasC),
    .hasH         (hasH),
    .pmpPresent   (pmpPresent),
    .pmpRuleCount (pmpRuleCount),
    .strobe       (strobe)
  );

  trp_dpath #(.XLEN(XLEN)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curVirt  (curVirt),
    .statIn   (statIn),
    .mepc     (mepc),
    .sepc     (sepc),
    .doneOk   (doneOk),
    .excValid (excValid),
    .excCause (excCause),
    .swapReq  (swapReq),
    .retPc    (retPc),
    .privOut  (privOut),
    .virtOut  (virtOut),
    .statOut  (statOut)
  );

  assign mieOut  = statOut.mie;
  assign sieOut  = statOut.sie;
  assign mpieOut = statOut.mpie;
  assign spieOut = statOut.spie;
  assign mppOut  = statOut.mpp;
  assign sppOut  = statOut.spp;
  assign mpvOut  = statOut.mpv;
  assign spvOut  = statOut.spv;
endmodule

// File: rtl/trp_chk.sv
module trp_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqIsMret,
  input logic [1:0]      curPriv,
  input logic            curVirt,
  input logic            hasC,
  input logic            pmpPresent,
  input logic [XLEN-1:0] mepc,
  input logic [XLEN-1:0] sepc,
  input logic            spieIn,
  input logic            sppIn,
  input logic            mpieIn,
  input logic [1:0]      mppIn,
  input logic            doneOk,
  input logic            excValid,
  input logic [4:0]      excCause,
  input logic            swapReq,
  input logic [XLEN-1:0] retPc,
  input logic [1:0]      privOut,
  input logic            virtOut,
  input logic            mieOut,
  input logic            sieOut,
  input logic            mpieOut,
  input logic            spieOut,
  input logic [1:0]      mppOut,
  input logic            sppOut,
  input logic            mpvOut
);
  assert_sret_user_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsMret && curPriv == 2'd0) |=> (excValid && excCause == 5'd2));

  assert_mret_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsMret && curPriv != 2'd3) |=> (excValid && excCause == 5'd2));

  assert_misalign_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curPriv == 2'd3 && !hasC &&
     ((reqIsMret ? mepc[1:0] : sepc[1:0]) != 2'd0)) |=> (excValid && excCause == 5'd0));

  assert_sret_stack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsMret && curPriv == 2'd3 && hasC && !curVirt) |=>
    (doneOk && spieOut && !sppOut && sieOut == $past(spieIn) &&
     privOut == {1'b0, $past(sppIn)} && retPc == $past(sepc)));

  assert_mret_stack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsMret && curPriv == 2'd3 && hasC && !pmpPresent) |=>
    (doneOk && mpieOut && mppOut == 2'd0 && !mpvOut && mieOut == $past(mpieIn) &&
     privOut == $past(mppIn) && retPc == $past(mepc)));

  assert_swap_R8: assert property (@(posedge clk) disable iff (!rstN)
    swapReq |-> (doneOk && virtOut));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> ($stable(privOut) && $stable(virtOut) && $stable(retPc) &&
                  $stable(mieOut) && $stable(sieOut) && $stable(mppOut)));

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && excValid));

  assert_origin_R11: assert property (@(posedge clk) disable iff (!rstN)
    (doneOk || excValid) |-> $past(reqValid));
endmodule

bind trp_top trp_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsMret(reqIsMret),
  .curPriv(curPriv), .curVirt(curVirt), .hasC(hasC), .pmpPresent(pmpPresent),
  .mepc(mepc), .sepc(sepc), .spieIn(spieIn), .sppIn(sppIn), .mpieIn(mpieIn),
  .mppIn(mppIn), .doneOk(doneOk), .excValid(excValid), .excCause(excCause),
  .swapReq(swapReq), .retPc(retPc), .privOut(privOut), .virtOut(virtOut),
  .mieOut(mieOut), .sieOut(sieOut), .mpieOut(mpieOut), .spieOut(spieOut),
  .mppOut(mppOut), .sppOut(sppOut), .mpvOut(mpvOut)
);

// File: tb/sim_trp_top.sv
module sim_trp_top;
  localparam int XLEN  = 32;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic reqValid, reqIsMret, curVirt;
  logic [1:0] curPriv;
  logic mieIn, sieIn, mpieIn, spieIn, sppIn, mpvIn, tsrIn, spvIn, vtsrIn;
  logic [1:0] mppIn;
  logic [XLEN-1:0] mepc, sepc;
  logic hasC, hasH, pmpPresent;
  logic [CNT_W-1:0] pmpRuleCount;
  logic doneOk, excValid, swapReq, virtOut;
  logic [4:0] excCause;
  logic [XLEN-1:0] retPc;
  logic [1:0] privOut, mppOut;
  logic mieOut, sieOut, mpieOut, spieOut, sppOut, mpvOut, spvOut;

  trp_top #(.XLEN(XLEN), .CNT_W(CNT_W)) u0 (.*);

  typedef struct packed {
    logic mret; logic [1:0] priv; logic virt;
    logic mie, sie, mpie, spie; logic [1:0] mpp; logic spp, mpv, tsr, spv, vtsr;
    logic [XLEN-1:0] mepc, sepc;
    logic hasC, hasH, pmp; logic [CNT_W-1:0] rules;
  } stim_t;

  // expected item: ok, cause, swap, pc, priv, virt, mie,sie,mpie,spie,mpp,spp,mpv,spv
  typedef struct packed {
    logic ok; logic [4:0] cause; logic swap; logic [XLEN-1:0] pc;
    logic [1:0] priv; logic virt; logic mie, sie, mpie, spie;
    logic [1:0] mpp; logic spp, mpv, spv;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  exp_t  held;
  int checks = 0;
  int errors = 0;
  logic running = 1'b0;

  function automatic stim_t baseStim();
    stim_t s;
    s = '0;
    s.priv = 2'd3; s.hasC = 1'b1; s.rules = 7'd4;
    s.mepc = 32'h0000_1000; s.sepc = 32'h0000_2000;
    return s;
  endfunction

  task automatic drive(input stim_t s, input string tag);
    exp_t e;
    logic bad;
    logic [XLEN-1:0] pcv;
    @(negedge clk); #1;
    pcv = s.mret ? s.mepc : s.sepc;
    e = held;
    e.ok = 1'b0; e.swap = 1'b0; e.cause = 5'd0;
    bad = 1'b1;
    if (s.mret ? (s.priv != 2'd3) : (s.priv == 2'd0)) e.cause = 5'd2;
    else if (!s.hasC && pcv[1:0] != 2'd0) e.cause = 5'd0;
    else if (!s.mret && s.tsr && s.priv != 2'd3) e.cause = 5'd2;
    else if (s.mret && s.pmp && s.rules == 0 && s.mpp != 2'd3) e.cause = 5'd2;
    else if (!s.mret && s.hasH && s.virt && s.vtsr) e.cause = 5'd22;
    else bad = 1'b0;
    if (!bad) begin
      e.ok = 1'b1; e.pc = pcv;
      e.mie = s.mie; e.sie = s.sie; e.mpie = s.mpie; e.spie = s.spie;
      e.mpp = s.mpp; e.spp = s.spp; e.mpv = s.mpv; e.spv = s.spv;
      e.virt = s.virt;
      if (s.mret) begin
        e.priv = s.mpp; e.mie = s.mpie; e.mpie = 1'b1; e.mpp = 2'd0; e.mpv = 1'b0;
        if (s.hasH) begin e.virt = s.mpv; e.swap = s.mpv; end
      end else begin
        e.priv = {1'b0, s.spp}; e.sie = s.spie; e.spie = 1'b1; e.spp = 1'b0;
        if (s.hasH && !s.virt) begin e.virt = s.spv; e.swap = s.spv; e.spv = 1'b0; end
      end
      held = e;
      held.ok = 1'b0; held.swap = 1'b0;
    end
    reqIsMret = s.mret; curPriv = s.priv; curVirt = s.virt;
    mieIn = s.mie; sieIn = s.sie; mpieIn = s.mpie; spieIn = s.spie;
    mppIn = s.mpp; sppIn = s.spp; mpvIn = s.mpv; tsrIn = s.tsr; spvIn = s.spv;
    vtsrIn = s.vtsr; mepc = s.mepc; sepc = s.sepc; hasC = s.hasC; hasH = s.hasH;
    pmpPresent = s.pmp; pmpRuleCount = s.rules;
    reqValid = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk); #1;
    reqValid = 1'b0;
  endtask

  function automatic exp_t actual();
    exp_t a;
    a.ok = doneOk; a.cause = excValid ? excCause : 5'd0; a.swap = swapReq;
    a.pc = retPc; a.priv = privOut; a.virt = virtOut;
    a.mie = mieOut; a.sie = sieOut; a.mpie = mpieOut; a.spie = spieOut;
    a.mpp = mppOut; a.spp = sppOut; a.mpv = mpvOut; a.spv = spvOut;
    return a;
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (running) begin
        if (doneOk || excValid) begin
          checks++;
          if (expQ.size() == 0) begin
            errors++;
            $display("FAIL R11 unexpected response: act ok=%0b exc=%0b exp none", doneOk, excValid);
          end else begin
            exp_t e, a;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            a = actual();
            if (a !== e || excValid !== !e.ok) begin
              errors++;
              $display("FAIL %s: act %h exc=%0b exp %h exc=%0b", t, a, excValid, e, !e.ok);
            end
          end
        end else if (expQ.size() != 0) begin
          string t;
          checks++; errors++;
          void'(expQ.pop_front());
          t = tagQ.pop_front();
          $display("FAIL R11 (%s): act no response exp response", t);
        end
      end
    end
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: act running exp finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    stim_t s;
    rstN = 1'b0; reqValid = 1'b0; reqIsMret = 1'b0; curPriv = 2'd3; curVirt = 1'b0;
    mieIn = 0; sieIn = 0; mpieIn = 0; spieIn = 0; mppIn = 0; sppIn = 0; mpvIn = 0;
    tsrIn = 0; spvIn = 0; vtsrIn = 0; mepc = '0; sepc = '0; hasC = 1; hasH = 0;
    pmpPresent = 0; pmpRuleCount = '0;
    held = '0; held.priv = 2'd3;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    checks++;
    if (actual() !== held || excValid !== 1'b0) begin
      errors++;
      $display("FAIL R12: act %h exc=%0b exp %h exc=0", actual(), excValid, held);
    end
    running = 1'b1;

    // R7 supervisor return from machine level, two stacking patterns
    s = baseStim(); s.spie = 1; s.spp = 1; s.sie = 0; s.mie = 1; s.mpp = 2'd1;
    drive(s, "R7");
    s = baseStim(); s.spie = 0; s.spp = 0; s.sie = 1; s.mpie = 1;
    drive(s, "R7");
    // R9 machine return, mpp supervisor then user
    s = baseStim(); s.mret = 1; s.mpie = 1; s.mpp = 2'd1; s.mpv = 1;
    drive(s, "R9");
    s = baseStim(); s.mret = 1; s.mpie = 0; s.mie = 1; s.mpp = 2'd0; s.sie = 1;
    drive(s, "R9");
    // R9 with hypervisor: virt restored from mpv, swap
    s = baseStim(); s.mret = 1; s.hasH = 1; s.mpv = 1; s.mpp = 2'd1; s.mpie = 1;
    drive(s, "R9");
    // R8 supervisor return, hypervisor on, virt off, spv set
    s = baseStim(); s.priv = 2'd1; s.hasH = 1; s.spv = 1; s.spp = 1; s.spie = 1;
    drive(s, "R8");
    // R8 with virt on: virt kept, spv kept
    s = baseStim(); s.priv = 2'd1; s.hasH = 1; s.virt = 1; s.spv = 1; s.spp = 0;
    drive(s, "R8");
    // R1 privilege violations; R10 state must hold
    s = baseStim(); s.priv = 2'd0; s.spie = 1;
    drive(s, "R1 R10");
    s = baseStim(); s.mret = 1; s.priv = 2'd1; s.mpie = 1;
    drive(s, "R1 R10");
    // R2 misaligned, and compressed present tolerates bit 1
    s = baseStim(); s.mret = 1; s.hasC = 0; s.mepc = 32'h0000_1002;
    drive(s, "R2");
    s = baseStim(); s.hasC = 0; s.sepc = 32'h0000_2001;
    drive(s, "R2");
    s = baseStim(); s.mret = 1; s.hasC = 1; s.mepc = 32'h0000_1002; s.mpp = 2'd3;
    drive(s, "R2");
    // R3 TSR at supervisor traps, at machine ignored
    s = baseStim(); s.priv = 2'd1; s.tsr = 1;
    drive(s, "R3");
    s = baseStim(); s.priv = 2'd3; s.tsr = 1; s.spp = 1;
    drive(s, "R3");
    // R4 VTSR
    s = baseStim(); s.priv = 2'd1; s.hasH = 1; s.virt = 1; s.vtsr = 1;
    drive(s, "R4");
    s = baseStim(); s.priv = 2'd1; s.hasH = 0; s.virt = 1; s.vtsr = 1; s.spie = 1;
    drive(s, "R4");
    // R5 protection-rule refusal and exemptions
    s = baseStim(); s.mret = 1; s.pmp = 1; s.rules = 0; s.mpp = 2'd1;
    drive(s, "R5");
    s = baseStim(); s.mret = 1; s.pmp = 1; s.rules = 0; s.mpp = 2'd3;
    drive(s, "R5");
    s = baseStim(); s.mret = 1; s.pmp = 1; s.rules = 7'd1; s.mpp = 2'd0;
    drive(s, "R5");
    // R6 priority
    s = baseStim(); s.priv = 2'd0; s.hasC = 0; s.sepc = 32'h3; s.tsr = 1;
    drive(s, "R6");
    s = baseStim(); s.priv = 2'd1; s.hasC = 0; s.sepc = 32'h2; s.tsr = 1;
    drive(s, "R6");
    s = baseStim(); s.priv = 2'd1; s.tsr = 1; s.hasH = 1; s.virt = 1; s.vtsr = 1;
    drive(s, "R6");
    s = baseStim(); s.mret = 1; s.hasC = 0; s.mepc = 32'h1; s.pmp = 1; s.rules = 0; s.mpp = 2'd0;
    drive(s, "R6");

    repeat (3) @(negedge clk);
    running = 1'b0;
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R11: act %0d pending exp 0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule